// File: doc/BRIEF.md
# Burst SRAM Command and Byte-Write Decoder

This block is the synchronous control front end of a burst SRAM model. Each rising clock edge samples the input pins: two chip enables, two address strobes, a burst-advance input and the write controls. The write controls are an all-bytes write, a byte-write enable and one enable per byte. From these the block decides what kind of cycle starts. The cycle is idle, a burst start at an externally supplied address, a burst step to the next address, or a burst hold at the current address. Each cycle that is not idle is a read or a write.

The processor-side strobe wins over the controller-side strobe, but it only counts while the primary enable is active. The second enable is looked at only on cycles that carry a strobe. A write can cover all bytes at once, which overrides the per-byte controls, or any subset of bytes. The results are registered. The array, the address counter and the output stage read them in the cycle that follows the sampling edge.

Top module: `burst_cmd_decoder`

## Requirements
- R1: While `rst` is high and after it, until the first decoded cycle, `addr_src` is 0, `rd_op` and `wr_op` are 0 and `byte_we` is all zero.
- R2: When `en_pri_n` is high, a low `strb_proc_n` is ignored. With `strb_ctrl_n` low in that state, the cycle is idle (`addr_src`=0, no read, no write).
- R3: With `en_pri_n` low, `en_sec` high and `strb_proc_n` low, the cycle starts a burst read at the external address (`addr_src`=1, `rd_op`=1) whatever the write controls are, and `byte_we` stays zero.
- R4: On a strobe cycle (either strobe effective) with `en_sec` low, the cycle is idle.
- R5: With `strb_proc_n` high, `strb_ctrl_n` low and both enables active, the cycle starts a burst at the external address (`addr_src`=1) as a read or write per the write decode.
- R6: With both strobes high and a burst in progress, `advance_n` low gives a step to the next address (`addr_src`=2), read or write per the write decode.
- R7: With both strobes high and a burst in progress, `advance_n` high gives a hold at the current address (`addr_src`=3), read or write per the write decode.
- R8: `wr_all_n` low makes a write with every bit of `byte_we` set, regardless of `wr_byte_en_n` and `byte_sel_n`.
- R9: With `wr_all_n` high and `wr_byte_en_n` low, `byte_we[i]` is set exactly when `byte_sel_n[i]` is low, in any combination. If no `byte_sel_n` bit is low, the cycle is a read.
- R10: With `wr_all_n` and `wr_byte_en_n` both high, the cycle is a read.
- R11: On cycles with both strobes high, `en_pri_n` and `en_sec` have no effect.
- R12: An idle cycle ends any burst. A later cycle with both strobes high is idle until a strobe starts a new burst.
- R13: The outputs for the inputs sampled at a rising edge appear just after that edge and hold for one cycle. `rd_op` and `wr_op` are never both 1, and `byte_we` is non-zero exactly when `wr_op` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en_pri_n | input | 1 | Primary chip enable, active low; gates the processor-side strobe |
| en_sec | input | 1 | Second chip enable, active high; checked on strobe cycles only |
| strb_proc_n | input | 1 | Processor-side address strobe, active low, higher priority |
| strb_ctrl_n | input | 1 | Controller-side address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Write all bytes, active low |
| wr_byte_en_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | NB | Per-byte write selects, active low, bit i is byte i |
| addr_src | output | 2 | Address source: 0 none, 1 external, 2 next, 3 current |
| rd_op | output | 1 | Cycle is a read |
| wr_op | output | 1 | Cycle is a write |
| byte_we | output | NB | Registered per-byte write strobes |

## Verification
Several corner cases are driven on purpose:
- **Masked processor-side strobe.** A low processor-side strobe is driven while the primary enable is off. A design that failed to mask it would start a read there instead of going idle.
- **Read-forcing strobe.** The processor-side strobe is driven together with an all-bytes write. A decoder that honoured the write inputs here would pulse write strobes.
- **Enables on non-strobe cycles.** The second enable is dropped on a burst step. A design that checked it on every cycle would cut the burst short.
- **Step after idle.** A step request is driven straight after an idle cycle. A design that kept the burst alive would report the next address.
- **Empty byte mask.** The byte-write enable is held active with every byte select high. A design without the fallback to read would raise a write with an empty mask.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_NEXT = 2'd2,
        SRC_CUR  = 2'd3
    } addr_src_e;

    typedef enum logic [1:0] {
        STRB_NONE = 2'd0,
        STRB_PROC = 2'd1,
        STRB_CTRL = 2'd2
    } strobe_e;

    typedef struct packed {
        addr_src_e src;
        logic      rd;
        logic      wr;
    } cyc_cmd_t;

    // Processor-side strobe has priority but is blocked by the primary enable.
    function automatic strobe_e resolve_strobe(input logic pri_n,
                                               input logic proc_n,
                                               input logic ctrl_n);
        if (!proc_n && !pri_n)
            return STRB_PROC;
        else if (!ctrl_n)
            return STRB_CTRL;
        else
            return STRB_NONE;
    endfunction

endpackage

// File: rtl/byte_write_decode.sv
module byte_write_decode
    import sram_ctl_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          all_n,
    input  logic          gate_n,
    input  logic [NB-1:0] sel_n,
    output logic [NB-1:0] mask,
    output logic          is_wr
);
    for (genvar i = 0; i < NB; i++) begin : g_lane
        always_comb begin
            if (!all_n)
                mask[i] = 1'b1;
            else
                mask[i] = !gate_n && !sel_n[i];
        end
    end

    assign is_wr = |mask;
endmodule

// File: rtl/cycle_classify.sv
module cycle_classify
    import sram_ctl_pkg::*;
(
    input  strobe_e  strb,
    input  logic     pri_n,
    input  logic     sec,
    input  logic     adv_n,
    input  logic     burst_on,
    input  logic     wr_req,
    output cyc_cmd_t cmd
);
    always_comb begin
        cmd = '{src: SRC_NONE, rd: 1'b0, wr: 1'b0};
        unique case (strb)
            STRB_PROC: begin
                if (sec) begin
                    cmd.src = SRC_EXT;
                    cmd.rd  = 1'b1;
                end
            end
            STRB_CTRL: begin
                if (!pri_n && sec) begin
                    cmd.src = SRC_EXT;
                    cmd.rd  = !wr_req;
                    cmd.wr  = wr_req;
                end
            end
            default: begin
                if (burst_on) begin
                    cmd.src = adv_n ? SRC_CUR : SRC_NEXT;
                    cmd.rd  = !wr_req;
                    cmd.wr  = wr_req;
                end
            end
        endcase
    end
endmodule

// File: rtl/burst_cmd_decoder.sv
module burst_cmd_decoder
    import sram_ctl_pkg::*;
#(
    parameter int NB = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_pri_n,
    input  logic          en_sec,
    input  logic          strb_proc_n,
    input  logic          strb_ctrl_n,
    input  logic          advance_n,
    input  logic          wr_all_n,
    input  logic          wr_byte_en_n,
    input  logic [NB-1:0] byte_sel_n,
    output logic [1:0]    addr_src,
    output logic          rd_op,
    output logic          wr_op,
    output logic [NB-1:0] byte_we
);
    localparam logic [NB-1:0] NO_BYTES = '0;

    strobe_e       strb;
    cyc_cmd_t      cmd_d;
    cyc_cmd_t      cmd_q;
    logic [NB-1:0] mask_d;
    logic [NB-1:0] we_q;
    logic          wr_req;
    logic          burst_q;

    assign strb = resolve_strobe(en_pri_n, strb_proc_n, strb_ctrl_n);

    byte_write_decode #(.NB(NB)) u_bw (
        .all_n  (wr_all_n),
        .gate_n (wr_byte_en_n),
        .sel_n  (byte_sel_n),
        .mask   (mask_d),
        .is_wr  (wr_req)
    );

    cycle_classify u_cls (
        .strb     (strb),
        .pri_n    (en_pri_n),
        .sec      (en_sec),
        .adv_n    (advance_n),
        .burst_on (burst_q),
        .wr_req   (wr_req),
        .cmd      (cmd_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '{src: SRC_NONE, rd: 1'b0, wr: 1'b0};
            we_q    <= NO_BYTES;
            burst_q <= 1'b0;
        end else begin
            cmd_q   <= cmd_d;
            we_q    <= cmd_d.wr ? mask_d : NO_BYTES;
            burst_q <= (cmd_d.src != SRC_NONE);
        end
    end

    assign addr_src = cmd_q.src;
    assign rd_op    = cmd_q.rd;
    assign wr_op    = cmd_q.wr;
    assign byte_we  = we_q;

    // R13: read and write never together; strobes only on writes
    a_r13_op_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rd_op, wr_op}));
    a_r13_strobe_needs_write: assert property (@(posedge clk) disable iff (rst)
        (byte_we != NO_BYTES) == wr_op);
    // R2: masked processor strobe with controller strobe low gives idle
    a_r2_masked_idle: assert property (@(posedge clk) disable iff (rst)
        ($past(en_pri_n) && !$past(strb_ctrl_n)) |-> (addr_src == SRC_NONE));
    // R3: processor strobe forces a read
    a_r3_proc_forces_read: assert property (@(posedge clk) disable iff (rst)
        (!$past(strb_proc_n) && !$past(en_pri_n)) |-> !wr_op);
    // R8: all-bytes write sets every strobe
    a_r8_all_bytes: assert property (@(posedge clk) disable iff (rst)
        (!$past(wr_all_n) && wr_op) |-> (&byte_we));
    // R10: no write controls active means no write
    a_r10_no_write: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_all_n) && $past(wr_byte_en_n)) |-> !wr_op);
    // R12: no strobe after an idle cycle stays idle
    a_r12_idle_sticky: assert property (@(posedge clk) disable iff (rst)
        ($past(strb_proc_n) && $past(strb_ctrl_n) && ($past(addr_src) == SRC_NONE))
        |-> (addr_src == SRC_NONE));
endmodule

// File: tb/tb_burst_cmd_decoder.sv
module tb_burst_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          en_pri_n, en_sec, strb_proc_n, strb_ctrl_n, advance_n;
    logic          wr_all_n, wr_byte_en_n;
    logic [NB-1:0] byte_sel_n;
    logic [1:0]    addr_src;
    logic          rd_op, wr_op;
    logic [NB-1:0] byte_we;

    int n_cmp = 0;
    int n_bad = 0;
    bit m_burst = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_cmd_decoder #(.NB(NB)) dut (
        .clk(clk), .rst(rst), .en_pri_n(en_pri_n), .en_sec(en_sec),
        .strb_proc_n(strb_proc_n), .strb_ctrl_n(strb_ctrl_n),
        .advance_n(advance_n), .wr_all_n(wr_all_n),
        .wr_byte_en_n(wr_byte_en_n), .byte_sel_n(byte_sel_n),
        .addr_src(addr_src), .rd_op(rd_op), .wr_op(wr_op), .byte_we(byte_we)
    );

    task automatic compare(string tag, int e_src, bit e_rd, bit e_wr, logic [NB-1:0] e_we);
        n_cmp++;
        if (addr_src !== e_src[1:0] || rd_op !== e_rd || wr_op !== e_wr || byte_we !== e_we) begin
            n_bad++;
            $display("FAIL %s: got src=%0d rd=%0b wr=%0b we=%b, expected src=%0d rd=%0b wr=%0b we=%b",
                     tag, addr_src, rd_op, wr_op, byte_we, e_src, e_rd, e_wr, e_we);
        end
    endtask

    // Behavioural reference: called at a negedge with inputs already set.
    task automatic step(string tag);
        int            e_src = 0;
        bit            e_rd = 0, e_wr = 0;
        logic [NB-1:0] e_we = '0;
        logic [NB-1:0] sel = '0;
        bit            want_wr = 0;
        if (!wr_all_n) begin
            sel = '1; want_wr = 1;
        end else if (!wr_byte_en_n && (~byte_sel_n) != '0) begin
            sel = ~byte_sel_n; want_wr = 1;
        end
        if (!strb_proc_n && !en_pri_n) begin
            if (en_sec) begin e_src = 1; e_rd = 1; end
        end else if (!strb_ctrl_n) begin
            if (!en_pri_n && en_sec) e_src = 1;
        end else if (m_burst) begin
            e_src = advance_n ? 3 : 2;
        end
        if (e_src != 0 && !(e_src == 1 && !strb_proc_n && !en_pri_n)) begin
            e_wr = want_wr; e_rd = !want_wr;
            if (want_wr) e_we = sel;
        end
        m_burst = (e_src != 0);
        @(posedge clk);
        #1;
        compare(tag, e_src, e_rd, e_wr, e_we);
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        en_pri_n = 0; en_sec = 1; strb_proc_n = 1; strb_ctrl_n = 1;
        advance_n = 1; wr_all_n = 1; wr_byte_en_n = 1; byte_sel_n = '1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1;
        idle_inputs();
        strb_ctrl_n = 0; wr_all_n = 0;   // busy inputs during reset must not matter
        repeat (3) @(posedge clk);
        #1;
        compare("R1 reset", 0, 0, 0, '0);
        @(negedge clk);
        rst = 0;
        idle_inputs();
        step("R1 idle after reset");

        // R2: masked processor strobe
        en_pri_n = 1; strb_ctrl_n = 0; step("R2 ctrl strobe with primary off");
        strb_ctrl_n = 1; strb_proc_n = 0; step("R2 proc strobe blocked");
        idle_inputs();

        // R3: processor strobe with write inputs active still reads
        strb_proc_n = 0; wr_all_n = 0; step("R3 proc strobe forces read");
        idle_inputs();
        // R4: second enable low on strobe cycles
        strb_proc_n = 0; en_sec = 0; step("R4 proc strobe second enable off");
        idle_inputs();
        strb_ctrl_n = 0; en_sec = 0; step("R4 ctrl strobe second enable off");
        idle_inputs();

        // R5 / R8: controller strobe start with all-bytes write
        strb_ctrl_n = 0; wr_all_n = 0; wr_byte_en_n = 1; byte_sel_n = '1;
        step("R5 R8 ctrl begin write all");
        idle_inputs();
        // R6 / R9: step with subset byte mask
        advance_n = 0; wr_byte_en_n = 0; byte_sel_n = 4'b1010; step("R6 R9 next write subset");
        byte_sel_n = 4'b0111; step("R9 single byte 3");
        // R9: byte enable active but no byte selected -> read
        byte_sel_n = 4'b1111; step("R9 empty mask reads");
        // R7 / R10: hold at current address, read
        idle_inputs(); advance_n = 1; step("R7 R10 hold read");
        // R8 overrides byte controls during hold
        wr_all_n = 0; wr_byte_en_n = 0; byte_sel_n = 4'b1110; step("R8 R7 all override");
        idle_inputs();
        // R11: enables ignored without strobe
        en_pri_n = 1; en_sec = 0; advance_n = 0; step("R11 enables ignored on step");
        idle_inputs();
        // R5 read via controller strobe
        strb_ctrl_n = 0; step("R5 ctrl begin read");
        // R12: idle then step
        idle_inputs(); en_pri_n = 1; strb_ctrl_n = 0; step("R12 idle cycle");
        idle_inputs(); advance_n = 0; step("R12 step after idle");
        advance_n = 1; step("R12 hold after idle");
        // R13: random stream checked against the model every cycle
        for (int k = 0; k < 400; k++) begin
            en_pri_n     = ($urandom_range(0, 3) == 0);
            en_sec       = ($urandom_range(0, 3) != 0);
            strb_proc_n  = ($urandom_range(0, 3) != 0);
            strb_ctrl_n  = ($urandom_range(0, 2) != 0);
            advance_n    = $urandom_range(0, 1);
            wr_all_n     = ($urandom_range(0, 3) != 0);
            wr_byte_en_n = $urandom_range(0, 1);
            byte_sel_n   = NB'($urandom);
            step("R13 random");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule